// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimator (Third-Order CIC)

This block turns the one-bit pulse-density stream of a second-order sigma-delta modulator into multi-bit samples of a slowly varying, near-DC sensor voltage. It is a cascaded integrator-comb low-pass filter. The integrator section advances once per accepted modulator bit, so at a 1.024 MHz bit rate it runs at that rate. The comb section runs once per block of `DEC_RATIO` accepted bits. This both suppresses the shaped quantisation noise and lowers the sample rate. With the defaults (three stages, ratio 256) the output rate is 4 kHz.

The modulator clock is presented as a one-cycle enable (`bit_en`) in the system clock domain, with the data bit beside it. Each decimated result is an unsigned word, 16 bits by default, so that software can read it as two bytes. All zeros in the stream maps to zero and a density of one half maps to mid-scale. A stream of all ones would reach exactly one step past the top of the word, so it saturates to all ones. A parameter selects how a bit enters the integrators: as 0/1, or as -1/+1 with the offset removed at the output. Both mappings give the same result word.

Top module: `cic_decimator`

## Requirements
- R1: While reset is asserted and at the first sample after its release, `smp_valid` is 0 and `smp_data` is 0. Reset clears every integrator and comb delay register.
- R2: A clock cycle with `bit_en` low leaves all filter state unchanged, and its `bit_in` value has no effect on any later result.
- R3: `smp_valid` is high for exactly one cycle per `DEC_RATIO` accepted bits counted from reset. It rises at the second rising edge counting the edge that samples the block's last accepted bit as the first. After reset with `bit_en` held high, the first pulse is therefore seen `DEC_RATIO`+1 cycles after the first bit is presented.
- R4: `smp_data` changes only in the cycle in which `smp_valid` is high, and holds its value between pulses.
- R5: A settled stream of all ones gives `smp_data` = 2^OUT_W-1 (saturated full scale).
- R6: A settled stream of all zeros gives `smp_data` = 0.
- R7: Take a repeating pattern with period P dividing `DEC_RATIO`, with k ones per period. From the fifth pulse after the pattern starts, every result equals floor(k·2^OUT_W/P), capped at 2^OUT_W-1. Alternating bits (P=2, k=1) give 2^(OUT_W-1).
- R8: The -1/+1 input mapping gives the same result words as R5 to R7 for the same streams, for any power-of-two ratio with OUT_W no larger than ORDER·log2(DEC_RATIO).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe marking a modulator bit |
| bit_in | input | 1 | Modulator output bit, sampled when `bit_en` is high |
| smp_valid | output | 1 | One-cycle strobe for a new decimated sample |
| smp_data | output | OUT_W | Unsigned decimated sample, held between strobes |

## Verification
The filter is driven with periodic streams whose period divides the block length. For these the settled output has an exact closed form, so each density step of one eighth tells a correct three-stage window sum apart from wrong stage counts, wrong mapping or wrong scaling. Constant ones and zeros probe the saturation corner and the floor. Alternating bits probe mid-scale. Streams with enable gaps and junk data in the idle cycles, and a long idle stretch followed by a resume, separate correct gating from state that leaks. A small bipolar configuration is swept over every density of a sixteen-bit period.

// File: rtl/cic_pkg.sv
package cic_pkg;

   typedef enum logic {
      MAP_UNIPOLAR = 1'b0,
      MAP_BIPOLAR  = 1'b1
   } cic_map_e;

   function automatic int growth_bits(input int order, input int ratio);
      return order * $clog2(ratio);
   endfunction

   function automatic int acc_bits(input int order, input int ratio, input cic_map_e m);
      return growth_bits(order, ratio) + 1 + ((m == MAP_BIPOLAR) ? 1 : 0);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cic_dec_ctr.sv
module cic_dec_ctr #(
   parameter int RATIO = 256
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic tick
);
   localparam int CW = $clog2(RATIO);
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= en && (cnt_q == LAST);
         if (en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
   parameter int ORDER = 3,
   parameter int W     = 25
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);
   for (genvar s = 0; s < ORDER; s++) begin : g_stage
      logic [W-1:0] feed;
      logic [W-1:0] acc_q;
      if (s == 0) begin : g_head
         assign feed = x;
      end else begin : g_tail
         assign feed = g_stage[s-1].acc_q;
      end
      always_ff @(posedge clk) begin
         if (rst) begin
            acc_q <= '0;
         end else if (en) begin
            acc_q <= acc_q + feed;
         end
      end
   end

   assign y = g_stage[ORDER-1].acc_q;
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
   parameter int ORDER = 3,
   parameter int W     = 25
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         fire,
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);
   for (genvar s = 0; s < ORDER; s++) begin : g_stage
      logic [W-1:0] din;
      logic [W-1:0] dly_q;
      logic [W-1:0] dif;
      if (s == 0) begin : g_head
         assign din = x;
      end else begin : g_tail
         assign din = g_stage[s-1].dif;
      end
      assign dif = din - dly_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            dly_q <= '0;
         end else if (fire) begin
            dly_q <= din;
         end
      end
   end

   assign y = g_stage[ORDER-1].dif;
endmodule

// File: rtl/cic_out_scale.sv
module cic_out_scale #(
   parameter int               G     = 24,
   parameter int               W     = 25,
   parameter int               OUT_W = 16,
   parameter cic_pkg::cic_map_e MAP  = cic_pkg::MAP_UNIPOLAR
) (
   input  logic [W-1:0]     d,
   output logic [OUT_W-1:0] q
);
   logic [G:0] u;

   if (MAP == cic_pkg::MAP_BIPOLAR) begin : g_bipolar
      localparam logic [W-1:0] OFS = W'(1) << G;
      logic [W-1:0] sum_w;
      assign sum_w = d + OFS;
      assign u     = (G+1)'(sum_w >> 1);
   end else begin : g_unipolar
      assign u = d[G:0];
   end

   assign q = u[G] ? {OUT_W{1'b1}} : u[G-1 -: OUT_W];
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator #(
   parameter int                ORDER     = 3,
   parameter int                DEC_RATIO = 256,
   parameter int                OUT_W     = 16,
   parameter cic_pkg::cic_map_e IN_MAP    = cic_pkg::MAP_UNIPOLAR
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_en,
   input  logic             bit_in,
   output logic             smp_valid,
   output logic [OUT_W-1:0] smp_data
);
   localparam int GROWTH = cic_pkg::growth_bits(ORDER, DEC_RATIO);
   localparam int ACC_W  = cic_pkg::acc_bits(ORDER, DEC_RATIO, IN_MAP);

   if (!cic_pkg::is_pow2(DEC_RATIO) || DEC_RATIO < 2) begin : g_bad_ratio
      $error("cic_decimator: DEC_RATIO must be a power of two of at least 2");
   end
   if (ORDER < 1) begin : g_bad_order
      $error("cic_decimator: ORDER must be at least 1");
   end
   if (OUT_W < 1 || OUT_W > GROWTH) begin : g_bad_width
      $error("cic_decimator: OUT_W must lie between 1 and the bit growth");
   end

   logic [ACC_W-1:0] x_in;
   logic [ACC_W-1:0] integ_out;
   logic [ACC_W-1:0] comb_out;
   logic [OUT_W-1:0] scaled;
   logic             dec_tick;

   if (IN_MAP == cic_pkg::MAP_BIPOLAR) begin : g_map_bip
      assign x_in = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};
   end else begin : g_map_uni
      assign x_in = {{(ACC_W-1){1'b0}}, bit_in};
   end

   cic_integ_chain #(.ORDER(ORDER), .W(ACC_W)) u_integ (
      .clk (clk),
      .rst (rst),
      .en  (bit_en),
      .x   (x_in),
      .y   (integ_out)
   );

   cic_dec_ctr #(.RATIO(DEC_RATIO)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .en   (bit_en),
      .tick (dec_tick)
   );

   cic_comb_chain #(.ORDER(ORDER), .W(ACC_W)) u_comb (
      .clk  (clk),
      .rst  (rst),
      .fire (dec_tick),
      .x    (integ_out),
      .y    (comb_out)
   );

   cic_out_scale #(.G(GROWTH), .W(ACC_W), .OUT_W(OUT_W), .MAP(IN_MAP)) u_scale (
      .d (comb_out),
      .q (scaled)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         smp_valid <= 1'b0;
         smp_data  <= '0;
      end else begin
         smp_valid <= dec_tick;
         if (dec_tick) begin
            smp_data <= scaled;
         end
      end
   end
endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
   parameter int DEC_RATIO = 256,
   parameter int OUT_W     = 16,
   parameter int ACC_W     = 25
) (
   input logic             clk,
   input logic             rst,
   input logic             bit_en,
   input logic             smp_valid,
   input logic [OUT_W-1:0] smp_data,
   input logic [ACC_W-1:0] integ_last
);
   localparam int CW = $clog2(DEC_RATIO);
   localparam logic [CW-1:0] LAST = CW'(DEC_RATIO - 1);

   logic [CW-1:0] blk_q;
   logic          due1_q;
   logic          due2_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         blk_q  <= '0;
         due1_q <= 1'b0;
         due2_q <= 1'b0;
      end else begin
         due1_q <= bit_en && (blk_q == LAST);
         due2_q <= due1_q;
         if (bit_en) begin
            blk_q <= blk_q + 1'b1;
         end
      end
   end

   AST_VALID_CADENCE: assert property (@(posedge clk) disable iff (rst) smp_valid == due2_q); // R3
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst) smp_valid |=> !smp_valid); // R3
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst) !smp_valid |-> $stable(smp_data)); // R4
   AST_GATED_INTEG: assert property (@(posedge clk) disable iff (rst) !bit_en |=> $stable(integ_last)); // R2
endmodule

bind cic_decimator cic_decimator_chk #(
   .DEC_RATIO (DEC_RATIO),
   .OUT_W     (OUT_W),
   .ACC_W     (ACC_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bit_en     (bit_en),
   .smp_valid  (smp_valid),
   .smp_data   (smp_data),
   .integ_last (integ_out)
);

// File: tb/cic_decimator_tb.sv
module cic_decimator_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic        en_b = 1'b0, bit_b = 1'b0, v_b;
   logic [15:0] d_b;
   logic        en_s = 1'b0, bit_s = 1'b0, v_s;
   logic [7:0]  d_s;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   cic_decimator u_dut (
      .clk(clk), .rst(rst), .bit_en(en_b), .bit_in(bit_b),
      .smp_valid(v_b), .smp_data(d_b)
   );

   cic_decimator #(.ORDER(3), .DEC_RATIO(16), .OUT_W(8),
                   .IN_MAP(cic_pkg::MAP_BIPOLAR)) u_dut_small (
      .clk(clk), .rst(rst), .bit_en(en_s), .bit_in(bit_s),
      .smp_valid(v_s), .smp_data(d_s)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // sel 0: default unipolar instance, sel 1: small bipolar instance
   task automatic run(input int sel, input int p, input int k, input bit gap,
                      input bit first, input int from);
      int ratio = sel ? 16 : 256;
      int full  = sel ? 256 : 65536;
      int exp   = (k * full) / p;
      string tag;
      int strobes = 0, j = 0, it = 0, last_it = 0, last_d;
      bit hold_bad = 1'b0;
      bit v;
      int d;
      if (exp > full - 1) exp = full - 1;
      if (sel) tag = "R8";
      else if (k == p) tag = "R5";
      else if (k == 0) tag = "R6";
      else tag = "R7";
      last_d = sel ? int'(d_s) : int'(d_b);
      while (strobes < from + 1) begin
         @(negedge clk);
         v = sel ? v_s : v_b;
         d = sel ? int'(d_s) : int'(d_b);
         if (v) begin
            strobes++;
            if (first && strobes == 1) chk("R3 first pulse cycle", it, ratio + 1);
            if (!gap && strobes == 3) chk("R3 pulse spacing", it - last_it, ratio);
            last_it = it;
            if (strobes >= from) chk(tag, d, exp);
            last_d = d;
         end else if (d != last_d) begin
            hold_bad = 1'b1;
         end
         begin
            logic e, b;
            e = gap ? (it % 2 == 0) : 1'b1;
            b = e ? ((j % p) < k) : 1'($urandom);
            if (e) j++;
            if (sel) begin en_s = e; bit_s = b; end
            else     begin en_b = e; bit_b = b; end
         end
         it++;
      end
      chk("R4 held between pulses", int'(hold_bad), 0);
      @(negedge clk);
      en_b = 1'b0; en_s = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R3 watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 valid during reset", int'(v_b), 0);
      chk("R1 data during reset", int'(d_b), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 valid after reset", int'(v_b), 0);
      chk("R1 data after reset", int'(d_b), 0);
      chk("R1 small valid after reset", int'(v_s), 0);
      chk("R1 small data after reset", int'(d_s), 0);

      run(0, 8, 4, 1'b0, 1'b1, 5);
      for (int k = 0; k <= 8; k++) run(0, 8, k, 1'b0, 1'b0, 5);
      run(0, 2, 1, 1'b0, 1'b0, 5);   // R7 alternating -> mid-scale
      run(0, 4, 1, 1'b1, 1'b0, 5);   // R2 gapped enable, junk data
      run(0, 4, 3, 1'b1, 1'b0, 5);   // R2
      run(0, 1, 1, 1'b0, 1'b0, 5);   // R5 settle before idle test

      // R2: long idle with random data, then resume
      begin
         bit saw_v = 1'b0;
         bit moved = 1'b0;
         for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (v_b) saw_v = 1'b1;
            if (d_b != 16'hFFFF) moved = 1'b1;
            en_b  = 1'b0;
            bit_b = 1'($urandom);
         end
         chk("R2 no pulse while idle", int'(saw_v), 0);
         chk("R2 data unchanged while idle", int'(moved), 0);
      end
      run(0, 1, 1, 1'b0, 1'b0, 1);   // R2 first result after resume

      run(1, 16, 8, 1'b0, 1'b1, 5);
      for (int k = 0; k <= 16; k++) run(1, 16, k, 1'b0, 1'b0, 5);
      run(1, 2, 1, 1'b0, 1'b0, 5);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule